// File: doc/BRIEF.md
# Block-Serial Weighted-Threshold Adder

This block adds two unsigned operands of `N` bits that arrive least significant block first, `BETA` bits of each operand per clock. Each block pair is added to a carry-in by a cascade of `BETA+1` threshold gates. Each gate weighs the operand bits by their binary value, subtracts the weights of the more significant sum bits already decided, and compares the result with the weight of its own bit position. A register stage follows every gate.

The most significant gate of the cascade decides the block carry. It sits directly behind the input register, so its output returns to the carry-in register in time for the next block pair. A new block pair can enter on every clock while earlier blocks are still travelling down the pipeline. Idle cycles between blocks keep the pending carry.

A start flag on the first block clears the carry-in. A last flag marks the final block, which may be narrower than `BETA` bits. Operand bits above that width are discarded. The carry out of the whole addition is reported with that final sum block.

Top module: `tla_serial_adder`

## Requirements
- R1: Each accepted block pair produces on `out_sum` bits `[k*BETA +: BETA]` of the full sum A+B, where k is the block's position counted from the least significant block.
- R2: The carry out of every accepted block is the carry-in of the next accepted block, whether the next block follows on the next clock or after any number of idle cycles.
- R3: The bits of the output stage, taken as a `BETA+1`-bit number, equal a + b + cin of the block they belong to.
- R4: A block accepted with `in_start` high uses carry-in 0, whatever carry the previous block produced.
- R5: A block accepted at a rising edge appears with `out_valid` high after exactly `BETA+1` further rising edges, and blocks leave in the order they entered.
- R6: On a block with `in_last` high, only the low `LAST_W = N - ((N-1)/BETA)*BETA` bits of `in_a` and `in_b` are used. The higher bits are ignored, `out_sum` shows only those low bits (higher bits 0), and `out_cout` gives the sum bit at position `LAST_W`, which is the carry out of the whole addition. `out_last` is high with that block.
- R7: `out_cout` is 0 in every cycle that does not carry a valid last block.
- R8: While and after reset, `out_valid` and `out_cout` are 0 and the pending carry is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A block pair is presented this cycle |
| in_start | input | 1 | This block is the first of an addition (carry-in 0) |
| in_last | input | 1 | This block is the final, possibly narrow, block |
| in_a | input | BETA | Block of operand A |
| in_b | input | BETA | Block of operand B |
| out_valid | output | 1 | A sum block is present |
| out_last | output | 1 | The present sum block is the final one |
| out_sum | output | BETA | Sum block |
| out_cout | output | 1 | Carry out of the whole addition, on the final block |

## Verification
Two functions can fall in the same cycle. The carry from the most significant gate returns to the carry-in register, and a start flag asks for a cleared carry-in on that same edge. The bench sends two blocks whose first block creates a carry, then sends the first block of a new addition on the very next clock with the start flag set. The new sum must show no trace of the abandoned carry. The random traffic mixes back-to-back blocks with idle gaps, so the carry is sometimes handed over on the next clock and sometimes after a gap. Every sum block is compared at its expected output cycle with slices of A+B computed in the bench.

// File: rtl/tla_pkg.sv
package tla_pkg;
   // width of the final, possibly narrow, block
   function automatic int tail_width(input int n, input int beta);
      return n - ((n - 1) / beta) * beta;
   endfunction
   // number of blocks in one operand
   function automatic int block_count(input int n, input int beta);
      return (n + beta - 1) / beta;
   endfunction
endpackage

// File: rtl/tla_gate.sv
// One threshold gate of the counting cascade: operand bits carry their binary
// weight, already decided higher sum bits carry a negative weight, and the gate
// fires when the total reaches the weight of its own position.
module tla_gate #(
   parameter int BETA = 4,
   parameter int POS  = 4
) (
   input  logic [BETA-1:0] a,
   input  logic [BETA-1:0] b,
   input  logic            cin,
   input  logic [BETA:0]   hi,
   output logic            y
);
   localparam int THRESH = 1 << POS;

   always_comb begin
      int acc;
      acc = cin ? 1 : 0;
      for (int i = 0; i < BETA; i++) begin
         if (a[i]) acc = acc + (1 << i);
         if (b[i]) acc = acc + (1 << i);
      end
      for (int j = 0; j <= BETA; j++) begin
         if (j > POS && hi[j]) acc = acc - (1 << j);
      end
      y = (acc >= THRESH);
   end
endmodule

// File: rtl/tla_stage.sv
// Pipeline register behind one gate level: the operands travel along, and the
// freshly decided sum bit is inserted at its position.
module tla_stage #(
   parameter int BETA = 4,
   parameter int POS  = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            d_v,
   input  logic            d_last,
   input  logic [BETA-1:0] d_a,
   input  logic [BETA-1:0] d_b,
   input  logic            d_cin,
   input  logic [BETA:0]   d_bits,
   input  logic            d_y,
   output logic            q_v,
   output logic            q_last,
   output logic [BETA-1:0] q_a,
   output logic [BETA-1:0] q_b,
   output logic            q_cin,
   output logic [BETA:0]   q_bits
);
   logic [BETA:0] bits_next;

   always_comb begin
      bits_next      = d_bits;
      bits_next[POS] = d_y;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_v    <= 1'b0;
         q_last <= 1'b0;
         q_a    <= '0;
         q_b    <= '0;
         q_cin  <= 1'b0;
         q_bits <= '0;
      end else begin
         q_v    <= d_v;
         q_last <= d_last;
         q_a    <= d_a;
         q_b    <= d_b;
         q_cin  <= d_cin;
         q_bits <= bits_next;
      end
   end

   // a decided bit never exceeds what the operands allow: bit set means value >= its weight
   assert_bit_reached_R3: assert property (@(posedge clk) disable iff (!rst_n)
      q_bits[POS] |-> ({1'b0, q_a} + {1'b0, q_b} + {{BETA{1'b0}}, q_cin}) >= (BETA+1)'(1 << POS));
endmodule

// File: rtl/tla_serial_adder.sv
module tla_serial_adder #(
   parameter int N    = 14,
   parameter int BETA = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic            in_start,
   input  logic            in_last,
   input  logic [BETA-1:0] in_a,
   input  logic [BETA-1:0] in_b,
   output logic            out_valid,
   output logic            out_last,
   output logic [BETA-1:0] out_sum,
   output logic            out_cout
);
   import tla_pkg::*;

   localparam int LAST_W = tail_width(N, BETA);
   localparam int LEVELS = BETA + 1;
   localparam logic [BETA-1:0] LAST_MASK = BETA'((1 << LAST_W) - 1);

   initial begin
      assert (BETA >= 1 && BETA <= 16) else $error("BETA out of range");
      assert (N >= BETA) else $error("N must be at least BETA");
   end

   // stage arrays: index 0 is the input register, index LEVELS the output register
   logic            st_v    [0:LEVELS];
   logic            st_last [0:LEVELS];
   logic [BETA-1:0] st_a    [0:LEVELS];
   logic [BETA-1:0] st_b    [0:LEVELS];
   logic            st_cin  [0:LEVELS];
   logic [BETA:0]   st_bits [0:LEVELS];
   logic            lvl_y   [0:BETA];

   logic carry_now, carry_hold, cin_sel;

   assign carry_now = lvl_y[0];
   assign cin_sel   = in_start ? 1'b0 : (st_v[0] ? carry_now : carry_hold);

   // input register with carry feedback
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_v[0]    <= 1'b0;
         st_last[0] <= 1'b0;
         st_a[0]    <= '0;
         st_b[0]    <= '0;
         st_cin[0]  <= 1'b0;
         carry_hold <= 1'b0;
      end else begin
         st_v[0] <= in_valid;
         if (in_valid) begin
            st_last[0] <= in_last;
            st_a[0]    <= in_last ? (in_a & LAST_MASK) : in_a;
            st_b[0]    <= in_last ? (in_b & LAST_MASK) : in_b;
            st_cin[0]  <= cin_sel;
         end
         if (st_v[0]) carry_hold <= carry_now;
      end
   end
   assign st_bits[0] = '0;

   // gate cascade, most significant bit first, a register behind every gate
   for (genvar k = 0; k < LEVELS; k++) begin : g_level
      tla_gate #(.BETA(BETA), .POS(BETA - k)) u_gate (
         .a   (st_a[k]),
         .b   (st_b[k]),
         .cin (st_cin[k]),
         .hi  (st_bits[k]),
         .y   (lvl_y[k])
      );
      tla_stage #(.BETA(BETA), .POS(BETA - k)) u_stage (
         .clk    (clk),
         .rst_n  (rst_n),
         .d_v    (st_v[k]),
         .d_last (st_last[k]),
         .d_a    (st_a[k]),
         .d_b    (st_b[k]),
         .d_cin  (st_cin[k]),
         .d_bits (st_bits[k]),
         .d_y    (lvl_y[k]),
         .q_v    (st_v[k+1]),
         .q_last (st_last[k+1]),
         .q_a    (st_a[k+1]),
         .q_b    (st_b[k+1]),
         .q_cin  (st_cin[k+1]),
         .q_bits (st_bits[k+1])
      );
   end

   assign out_valid = st_v[LEVELS];
   assign out_last  = st_v[LEVELS] & st_last[LEVELS];
   assign out_sum   = st_last[LEVELS] ? (st_bits[LEVELS][BETA-1:0] & LAST_MASK)
                                      : st_bits[LEVELS][BETA-1:0];
   assign out_cout  = st_v[LEVELS] & st_last[LEVELS] & st_bits[LEVELS][LAST_W];

   // cascade result equals the arithmetic sum of its block
   assert_block_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
      st_v[LEVELS] |-> st_bits[LEVELS] ==
         ({1'b0, st_a[LEVELS]} + {1'b0, st_b[LEVELS]} + {{BETA{1'b0}}, st_cin[LEVELS]}));

   // back-to-back handover of the carry decided by the top gate
   assert_carry_chain_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_v[0] && in_valid && !in_start) |=> st_cin[0] == $past(carry_now));

   // start clears the carry-in
   assert_start_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_start) |=> !st_cin[0]);

   // final carry only with a final block
   assert_cout_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_valid && out_last) |-> !out_cout);
endmodule

// File: tb/sim_tla_serial_adder.sv
`timescale 1ns/1ps
module sim_tla_serial_adder;
   localparam int N      = 14;
   localparam int BETA   = 4;
   localparam int NBLK   = (N + BETA - 1) / BETA;
   localparam int LAST_W = N - ((N - 1) / BETA) * BETA;
   localparam int LAT    = BETA + 2;   // drive negedge -> sample negedge

   logic clk = 1'b0, rst_n = 1'b0;
   logic in_valid = 1'b0, in_start = 1'b0, in_last = 1'b0;
   logic [BETA-1:0] in_a = '0, in_b = '0;
   logic out_valid, out_last, out_cout;
   logic [BETA-1:0] out_sum;

   always #10 clk = ~clk;   // 50 MHz

   tla_serial_adder #(.N(N), .BETA(BETA)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
      .in_last(in_last), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
      .out_last(out_last), .out_sum(out_sum), .out_cout(out_cout));

   int checks = 0, fails = 0, cyc = 0;
   bit done = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // expected output ring
   logic [BETA-1:0] e_sum [0:63];
   logic            e_cout[0:63];
   logic            e_last[0:63];
   int              e_cyc [0:63];
   int wr = 0, rd = 0;

   function automatic logic [N:0] full_sum(input logic [N-1:0] a, input logic [N-1:0] b);
      return {1'b0, a} + {1'b0, b};
   endfunction

   function automatic logic [BETA-1:0] slice(input logic [N:0] s, input int k, input bit last);
      logic [N:0] t = s >> (k * BETA);
      logic [BETA-1:0] m = last ? BETA'((1 << LAST_W) - 1) : '1;
      return t[BETA-1:0] & m;
   endfunction

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0;
      in_a = BETA'($urandom); in_b = BETA'($urandom);
   endtask

   // one addition; nsend < NBLK abandons it early; gap_pct is idle probability
   task automatic op(input logic [N-1:0] a, input logic [N-1:0] b, input int nsend, input int gap_pct);
      logic [N:0] s = full_sum(a, b);
      logic [NBLK*BETA-1:0] aw = (NBLK*BETA)'(a), bw = (NBLK*BETA)'(b);
      for (int k = 0; k < nsend; k++) begin
         bit last = (k == NBLK - 1);
         while (k > 0 && ($urandom % 100) < gap_pct) idle();
         @(negedge clk);
         in_valid = 1'b1; in_start = (k == 0); in_last = last;
         in_a = aw[k*BETA +: BETA];
         in_b = bw[k*BETA +: BETA];
         if (last) begin   // junk above the narrow width must be ignored (R6)
            for (int i = LAST_W; i < BETA; i++) begin
               in_a[i] = 1'($urandom); in_b[i] = 1'($urandom);
            end
         end
         e_sum[wr]  = slice(s, k, last);
         e_cout[wr] = last ? s[N] : 1'b0;
         e_last[wr] = last;
         e_cyc[wr]  = cyc + LAT;
         wr = (wr + 1) % 64;
      end
   endtask

   // output monitor
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (out_valid) begin
            if (rd == wr) begin
               checks++; fails++;
               $display("FAIL R5 unexpected block: actual sum %h expected none", out_sum);
            end else begin
               checks++;
               if (out_sum !== e_sum[rd]) begin
                  fails++;
                  $display("FAIL %s sum block: actual %h expected %h",
                           e_last[rd] ? "R6" : "R1", out_sum, e_sum[rd]);
               end
               checks++;
               if (out_cout !== e_cout[rd] || out_last !== e_last[rd]) begin
                  fails++;
                  $display("FAIL R6 cout/last: actual %b/%b expected %b/%b",
                           out_cout, out_last, e_cout[rd], e_last[rd]);
               end
               checks++;
               if (cyc != e_cyc[rd]) begin
                  fails++;
                  $display("FAIL R5 latency: actual cycle %0d expected %0d", cyc, e_cyc[rd]);
               end
               rd = (rd + 1) % 64;
            end
         end else begin
            checks++;
            if (out_cout !== 1'b0) begin
               fails++;
               $display("FAIL R7 cout without final block: actual %b expected 0", out_cout);
            end
            if (rd != wr && cyc > e_cyc[rd]) begin
               checks++; fails++;
               $display("FAIL R5 missing block: actual none expected sum %h", e_sum[rd]);
               rd = (rd + 1) % 64;
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      done = 1;
      summary();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      checks++;   // R8 reset state
      if (out_valid !== 1'b0 || out_cout !== 1'b0) begin
         fails++;
         $display("FAIL R8 reset: actual valid %b cout %b expected 0 0", out_valid, out_cout);
      end
      rst_n = 1'b1;
      idle();
      checks++;   // R8 still quiet after release
      if (out_valid !== 1'b0) begin
         fails++;
         $display("FAIL R8 after reset: actual valid %b expected 0", out_valid);
      end
      // R2 carry ripples through every block back-to-back
      op(14'h3FFF, 14'h0001, NBLK, 0);
      // R2 ripple with gaps
      op(14'h3FFF, 14'h3FFF, NBLK, 80);
      // R4 abandoned addition leaves a carry; new start on the very next clock
      op(14'h000F, 14'h0001, 1, 0);
      op(14'h0000, 14'h0000, NBLK, 0);
      op(14'h00FF, 14'h0001, 2, 0);
      op(14'h1234, 14'h0F0F, NBLK, 0);
      // R1 random traffic, mixed gaps
      for (int t = 0; t < 300; t++)
         op(N'($urandom), N'($urandom), NBLK, (t % 3) * 30);
      repeat (3 * LAT) idle();
      checks++;   // R5 every block emerged
      if (rd != wr) begin
         fails++;
         $display("FAIL R5 drain: actual %0d pending expected 0", (wr - rd + 64) % 64);
      end
      done = 1;
      summary();
   end
endmodule